// File: doc/BRIEF.md
# Rename Buffer with Tag Forwarding

This block holds speculative results in a small circular pool of rename entries until in-order retirement commits them to an architected register array. Each cycle, dispatch can claim up to two entries. Each entry that is granted returns a tag and records the architected register it will eventually update. Execution units publish results on a single broadcast port, addressed by tag. A dependent instruction holds a tag and uses a lookup port to learn whether its operand has arrived. The lookup forwards a value that is being broadcast in the same cycle.

Retirement drains the oldest entries first, at most two per cycle. An entry retires only once its data is present, and the second slot retires only together with the first. When a branch is found mispredicted, the caller gives a keep count: the number of oldest entries that belong to instructions up to the branch. Every entry younger than that point is released in one cycle, and allocation resumes directly behind the survivors.

Execution units, reservation stations and branch resolution are outside the block. They appear only as stimulus on its ports.

Top module: `rename_buffer`

## Requirements
- R1: After a synchronous reset the pool is empty. The offered tags are 0 and 1, no stall is raised for an idle request, every lookup reports not ready, and every architected register reads zero.
- R2: An accepted request takes the entry at the allocation pointer for slot 0 (alloc_tag0) and the next entry in circular order for slot 1 (alloc_tag1). Slot 1 counts only when slot 0 is also requested. A request is granted all-or-nothing, and the pointer advances by the number granted.
- R3: The pool holds six entries. alloc_stall is high whenever the granted request would need more entries than are free. A stalled request claims nothing.
- R4: A broadcast with wb_valid marks the tagged occupied entry as holding data. A lookup of that tag reports ready with the value in the same cycle as the broadcast and in every later cycle.
- R5: A lookup reports not ready for an occupied entry that has no data yet, and for any tag that is not occupied. A broadcast to a tag that is not occupied is ignored.
- R6: Retirement is strictly oldest-first. The oldest entry commits only if ret_en0 is high and its data is present. The next entry commits only if ret_en1 is high, the oldest also commits, and its own data is present. ret_done reports both outcomes in the same cycle (bit 0 for oldest), and committed values are readable on the architected port from the next cycle.
- R7: When two retiring entries in one cycle name the same architected register, the younger entry's value is the one kept.
- R8: With sq_valid high, entries at age positions at or beyond sq_keep (the oldest entry is position 0; the keep count is limited to the current occupancy) are released. Those positions cannot retire in that cycle. The next allocation is placed directly after the last kept entry.
- R9: An entry that is reused after retirement or release starts without data, whatever it held before.
- R10: No allocation is granted in a cycle with sq_valid high, and alloc_stall is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en0 | input | 1 | Request one entry in slot 0 |
| alloc_en1 | input | 1 | Request a second entry in slot 1 (only with slot 0) |
| alloc_dst0 | input | 5 | Architected destination for slot 0 |
| alloc_dst1 | input | 5 | Architected destination for slot 1 |
| alloc_stall | output | 1 | Request not granted this cycle |
| alloc_tag0 | output | 3 | Tag given to slot 0 |
| alloc_tag1 | output | 3 | Tag given to slot 1 |
| wb_valid | input | 1 | Result broadcast strobe |
| wb_tag | input | 3 | Tag of the broadcast result |
| wb_data | input | 32 | Broadcast result value |
| src_tag | input | 3 | Tag a consumer is waiting on |
| src_ready | output | 1 | Operand for src_tag available |
| src_data | output | 32 | Operand value for src_tag |
| ret_en0 | input | 1 | Retire the oldest entry |
| ret_en1 | input | 1 | Retire the second oldest entry |
| ret_done | output | 2 | Entries actually retired this cycle |
| sq_valid | input | 1 | Mispredict squash strobe |
| sq_keep | input | 3 | Number of oldest entries that survive the squash |
| arch_rd_idx | input | 5 | Architected register read index |
| arch_rd_data | output | 32 | Architected register read value |

## Verification
A stale allocation pointer or occupancy count shows up immediately. The next grant carries the wrong tag, or a stall appears one entry too early or too late. A squash that keeps the wrong number of entries shows in the first allocation after it. A ready bit that is not cleared on reuse makes a lookup of a freshly granted tag report ready in the very next cycle. A wrong retirement choice, such as skipping a not-yet-ready oldest entry or picking the wrong one of two writes to the same register, becomes visible on the architected read port one cycle after ret_done.

// File: rtl/rnb_pkg.sv
package rnb_pkg;

    localparam int RNB_ENTRIES   = 6;
    localparam int RNB_ARCH_REGS = 32;
    localparam int RNB_DATA_W    = 32;

    // How the ring pointers move in a given cycle
    typedef enum logic {
        RING_ADVANCE = 1'b0,
        RING_REWIND  = 1'b1
    } ring_mode_e;

    // Circular increment within a ring of 'size' slots
    function automatic int unsigned ring_add(int unsigned base, int unsigned inc,
                                             int unsigned size);
        return (base + inc) % size;
    endfunction

    // Age position of slot 'idx' when the oldest slot is 'head'
    function automatic int unsigned ring_pos(int unsigned idx, int unsigned head,
                                             int unsigned size);
        return (idx + size - head) % size;
    endfunction

endpackage

// File: rtl/rnb_ring_ctrl.sv
module rnb_ring_ctrl
    import rnb_pkg::*;
#(
    parameter int N = RNB_ENTRIES,
    localparam int TW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_en0,
    input  logic          alloc_en1,
    input  logic          sq_valid,
    input  logic [CW-1:0] sq_keep_eff,
    input  logic [1:0]    ret_n,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          alloc_stall,
    output logic [1:0]    alloc_take
);

    logic [1:0]  req_n;
    logic [CW:0] free_n;
    ring_mode_e  mode;

    assign req_n  = {1'b0, alloc_en0} + {1'b0, alloc_en0 & alloc_en1};
    assign free_n = (CW + 1)'(N) - {1'b0, count};

    assign alloc_stall = sq_valid | ((CW + 1)'(req_n) > free_n);
    assign alloc_take  = alloc_stall ? 2'd0 : req_n;
    assign mode        = sq_valid ? RING_REWIND : RING_ADVANCE;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head <= TW'(ring_add(32'(head), 32'(ret_n), N));
            case (mode)
                RING_REWIND: begin
                    tail  <= TW'(ring_add(32'(head), 32'(sq_keep_eff), N));
                    count <= sq_keep_eff - CW'(ret_n);
                end
                default: begin
                    tail  <= TW'(ring_add(32'(tail), 32'(alloc_take), N));
                    count <= count + CW'(alloc_take) - CW'(ret_n);
                end
            endcase
        end
    end

    // R3: occupancy never exceeds the pool size
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(N));

    // R8: after a squash no more than the kept entries remain
    p_squash_shrinks_r8: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> count <= $past(sq_keep_eff));

endmodule

// File: rtl/rnb_entry_pool.sv
module rnb_entry_pool
    import rnb_pkg::*;
#(
    parameter int N  = RNB_ENTRIES,
    parameter int AW = 5,
    parameter int DW = RNB_DATA_W,
    localparam int TW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TW-1:0]          head,
    input  logic [TW-1:0]          tail,
    input  logic [CW-1:0]          count,
    input  logic [1:0]             alloc_take,
    input  logic [AW-1:0]          alloc_dst0,
    input  logic [AW-1:0]          alloc_dst1,
    input  logic                   wb_valid,
    input  logic [TW-1:0]          wb_tag,
    input  logic [DW-1:0]          wb_data,
    input  logic [TW-1:0]          src_tag,
    output logic                   src_ready,
    output logic [DW-1:0]          src_data,
    output logic [N-1:0]           vld,
    output logic [N-1:0][AW-1:0]   dst,
    output logic [N-1:0][DW-1:0]   data
);

    logic [N-1:0]  occ;
    logic [TW-1:0] tail_nxt;
    logic          src_in_range;
    logic [TW-1:0] src_idx;
    logic          src_wb_hit;

    assign tail_nxt = TW'(ring_add(32'(tail), 1, N));

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic slot0_hit;
        logic slot1_hit;
        logic wb_hit;

        assign occ[i]    = ring_pos(i, 32'(head), N) < 32'(count);
        assign slot0_hit = (alloc_take != 2'd0) && (tail == TW'(i));
        assign slot1_hit = (alloc_take == 2'd2) && (tail_nxt == TW'(i));
        assign wb_hit    = wb_valid && (wb_tag == TW'(i)) && occ[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                vld[i]  <= 1'b0;
                dst[i]  <= '0;
                data[i] <= '0;
            end else if (slot0_hit) begin
                vld[i] <= 1'b0;
                dst[i] <= alloc_dst0;
            end else if (slot1_hit) begin
                vld[i] <= 1'b0;
                dst[i] <= alloc_dst1;
            end else if (wb_hit) begin
                vld[i]  <= 1'b1;
                data[i] <= wb_data;
            end
        end
    end

    // Operand lookup with same-cycle bypass from the broadcast port
    assign src_in_range = 32'(src_tag) < N;
    assign src_idx      = src_in_range ? src_tag : '0;
    assign src_wb_hit   = wb_valid && (wb_tag == src_tag);
    assign src_ready    = src_in_range && occ[src_idx] && (vld[src_idx] || src_wb_hit);
    assign src_data     = vld[src_idx] ? data[src_idx] : wb_data;

    // R9: a freshly granted entry never starts with data
    p_alloc_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (alloc_take != 2'd0) |=> !vld[$past(tail)]);

endmodule

// File: rtl/rnb_arch_file.sv
module rnb_arch_file
    import rnb_pkg::*;
#(
    parameter int R  = RNB_ARCH_REGS,
    parameter int DW = RNB_DATA_W,
    localparam int AW = $clog2(R)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we0,
    input  logic [AW-1:0] idx0,
    input  logic [DW-1:0] d0,
    input  logic          we1,
    input  logic [AW-1:0] idx1,
    input  logic [DW-1:0] d1,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] regs [R];

    // Port 1 carries the younger retirement and is applied last
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < R; r++) regs[r] <= '0;
        end else begin
            if (we0) regs[idx0] <= d0;
            if (we1) regs[idx1] <= d1;
        end
    end

    assign rd_data = regs[rd_idx];

    // R7: the younger of two same-register commits survives
    p_younger_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (we0 && we1 && idx0 == idx1) |=> regs[$past(idx1)] == $past(d1));

endmodule

// File: rtl/rename_buffer.sv
module rename_buffer
    import rnb_pkg::*;
#(
    parameter int N_ENTRIES = RNB_ENTRIES,
    parameter int ARCH_REGS = RNB_ARCH_REGS,
    parameter int DATA_W    = RNB_DATA_W,
    localparam int TW = $clog2(N_ENTRIES),
    localparam int CW = $clog2(N_ENTRIES + 1),
    localparam int AW = $clog2(ARCH_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en0,
    input  logic              alloc_en1,
    input  logic [AW-1:0]     alloc_dst0,
    input  logic [AW-1:0]     alloc_dst1,
    output logic              alloc_stall,
    output logic [TW-1:0]     alloc_tag0,
    output logic [TW-1:0]     alloc_tag1,
    input  logic              wb_valid,
    input  logic [TW-1:0]     wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [TW-1:0]     src_tag,
    output logic              src_ready,
    output logic [DATA_W-1:0] src_data,
    input  logic              ret_en0,
    input  logic              ret_en1,
    output logic [1:0]        ret_done,
    input  logic              sq_valid,
    input  logic [CW-1:0]     sq_keep,
    input  logic [AW-1:0]     arch_rd_idx,
    output logic [DATA_W-1:0] arch_rd_data
);

    logic [TW-1:0]                 head, tail, head_nxt;
    logic [CW-1:0]                 count, keep_eff;
    logic [1:0]                    alloc_take, ret_n;
    logic [N_ENTRIES-1:0]          vld;
    logic [N_ENTRIES-1:0][AW-1:0]  dst;
    logic [N_ENTRIES-1:0][DATA_W-1:0] data;
    logic                          keep_ok0, keep_ok1;

    // Keep count limited to what is actually occupied
    assign keep_eff = (sq_keep > count) ? count : sq_keep;

    rnb_ring_ctrl #(.N(N_ENTRIES)) u_ring (
        .clk         (clk),
        .rst         (rst),
        .alloc_en0   (alloc_en0),
        .alloc_en1   (alloc_en1),
        .sq_valid    (sq_valid),
        .sq_keep_eff (keep_eff),
        .ret_n       (ret_n),
        .head        (head),
        .tail        (tail),
        .count       (count),
        .alloc_stall (alloc_stall),
        .alloc_take  (alloc_take)
    );

    rnb_entry_pool #(.N(N_ENTRIES), .AW(AW), .DW(DATA_W)) u_pool (
        .clk        (clk),
        .rst        (rst),
        .head       (head),
        .tail       (tail),
        .count      (count),
        .alloc_take (alloc_take),
        .alloc_dst0 (alloc_dst0),
        .alloc_dst1 (alloc_dst1),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_data    (wb_data),
        .src_tag    (src_tag),
        .src_ready  (src_ready),
        .src_data   (src_data),
        .vld        (vld),
        .dst        (dst),
        .data       (data)
    );

    assign alloc_tag0 = tail;
    assign alloc_tag1 = TW'(ring_add(32'(tail), 1, N_ENTRIES));

    // In-order retirement: oldest first, second only behind the first
    assign head_nxt = TW'(ring_add(32'(head), 1, N_ENTRIES));
    assign keep_ok0 = !sq_valid || (keep_eff >= CW'(1));
    assign keep_ok1 = !sq_valid || (keep_eff >= CW'(2));

    assign ret_done[0] = ret_en0 && (count >= CW'(1)) && vld[head] && keep_ok0;
    assign ret_done[1] = ret_done[0] && ret_en1 && (count >= CW'(2))
                         && vld[head_nxt] && keep_ok1;
    assign ret_n       = {1'b0, ret_done[0]} + {1'b0, ret_done[1]};

    rnb_arch_file #(.R(ARCH_REGS), .DW(DATA_W)) u_arch (
        .clk     (clk),
        .rst     (rst),
        .we0     (ret_done[0]),
        .idx0    (dst[head]),
        .d0      (data[head]),
        .we1     (ret_done[1]),
        .idx1    (dst[head_nxt]),
        .d1      (data[head_nxt]),
        .rd_idx  (arch_rd_idx),
        .rd_data (arch_rd_data)
    );

    // R6: a commit always comes from an occupied entry that has its data
    p_ret_has_data_r6: assert property (@(posedge clk) disable iff (rst)
        ret_done[0] |-> (count != '0) && vld[head]);

    // R10: the squash cycle grants nothing
    p_squash_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> (alloc_take == 2'd0) && alloc_stall);

endmodule

// File: tb/rename_buffer_tb_top.sv
`timescale 1ns/1ps
module rename_buffer_tb_top;

    localparam int TW = 3;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          alloc_en0, alloc_en1;
    logic [AW-1:0] alloc_dst0, alloc_dst1;
    logic          alloc_stall;
    logic [TW-1:0] alloc_tag0, alloc_tag1;
    logic          wb_valid;
    logic [TW-1:0] wb_tag;
    logic [DW-1:0] wb_data;
    logic [TW-1:0] src_tag;
    logic          src_ready;
    logic [DW-1:0] src_data;
    logic          ret_en0, ret_en1;
    logic [1:0]    ret_done;
    logic          sq_valid;
    logic [CW-1:0] sq_keep;
    logic [AW-1:0] arch_rd_idx;
    logic [DW-1:0] arch_rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rename_buffer dut_i (
        .clk(clk), .rst(rst),
        .alloc_en0(alloc_en0), .alloc_en1(alloc_en1),
        .alloc_dst0(alloc_dst0), .alloc_dst1(alloc_dst1),
        .alloc_stall(alloc_stall), .alloc_tag0(alloc_tag0), .alloc_tag1(alloc_tag1),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .src_tag(src_tag), .src_ready(src_ready), .src_data(src_data),
        .ret_en0(ret_en0), .ret_en1(ret_en1), .ret_done(ret_done),
        .sq_valid(sq_valid), .sq_keep(sq_keep),
        .arch_rd_idx(arch_rd_idx), .arch_rd_data(arch_rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_en0 = 0; alloc_en1 = 0; alloc_dst0 = '0; alloc_dst1 = '0;
        wb_valid = 0; wb_tag = '0; wb_data = '0; src_tag = '0;
        ret_en0 = 0; ret_en1 = 0; sq_valid = 0; sq_keep = '0; arch_rd_idx = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // All cycle tasks start and end 1 ns after a rising edge
    task automatic do_alloc(input logic e0, input logic e1, input logic [AW-1:0] d0,
                            input logic [AW-1:0] d1, output logic st,
                            output logic [TW-1:0] t0, output logic [TW-1:0] t1);
        alloc_en0 = e0; alloc_en1 = e1; alloc_dst0 = d0; alloc_dst1 = d1;
        #1 st = alloc_stall; t0 = alloc_tag0; t1 = alloc_tag1;
        @(posedge clk); #1;
        alloc_en0 = 0; alloc_en1 = 0;
    endtask

    task automatic do_wb(input logic [TW-1:0] t, input logic [DW-1:0] d);
        wb_valid = 1; wb_tag = t; wb_data = d;
        @(posedge clk); #1;
        wb_valid = 0;
    endtask

    task automatic do_retire(input logic e0, input logic e1, output logic [1:0] done);
        ret_en0 = e0; ret_en1 = e1;
        #1 done = ret_done;
        @(posedge clk); #1;
        ret_en0 = 0; ret_en1 = 0;
    endtask

    task automatic do_look(input logic [TW-1:0] t, output logic rdy, output logic [DW-1:0] d);
        src_tag = t;
        #1 rdy = src_ready; d = src_data;
        @(posedge clk); #1;
    endtask

    task automatic do_arch(input logic [AW-1:0] idx, output logic [DW-1:0] d);
        arch_rd_idx = idx;
        #1 d = arch_rd_data;
        @(posedge clk); #1;
    endtask

    task automatic t_reset_state();
        logic rdy; logic [DW-1:0] d;
        do_reset();
        #1;
        check("R1 stall idle", alloc_stall, 0);
        check("R1 tag0", alloc_tag0, 0);
        check("R1 tag1", alloc_tag1, 1);
        @(posedge clk); #1;
        do_look(3'd0, rdy, d);
        check("R1 lookup not ready", rdy, 0);
        do_arch(5'd0, d);
        check("R1 arch r0", d, 0);
        do_arch(5'd31, d);
        check("R1 arch r31", d, 0);
    endtask

    task automatic t_alloc_fill();
        logic st; logic [TW-1:0] t0, t1;
        do_reset();
        do_alloc(0, 1, 5'd9, 5'd9, st, t0, t1);
        check("R2 slot1 alone stall", st, 0);
        do_alloc(1, 1, 5'd1, 5'd2, st, t0, t1);
        check("R2 first pair tag0 (slot1 alone took none)", t0, 0);
        check("R2 first pair tag1", t1, 1);
        do_alloc(1, 1, 5'd3, 5'd4, st, t0, t1);
        check("R2 second pair tag0", t0, 2);
        check("R2 second pair tag1", t1, 3);
        do_alloc(1, 0, 5'd5, 5'd0, st, t0, t1);
        check("R2 single tag", t0, 4);
        check("R3 single grant no stall", st, 0);
        do_alloc(1, 1, 5'd6, 5'd7, st, t0, t1);
        check("R3 pair with one free stalls", st, 1);
        do_alloc(1, 0, 5'd6, 5'd0, st, t0, t1);
        check("R3 last entry granted", st, 0);
        check("R3 stalled pair claimed nothing", t0, 5);
        do_alloc(1, 0, 5'd8, 5'd0, st, t0, t1);
        check("R3 full pool stalls", st, 1);
    endtask

    task automatic t_forward();
        logic st; logic [TW-1:0] t0, t1; logic rdy; logic [DW-1:0] d;
        do_reset();
        do_alloc(1, 1, 5'd3, 5'd4, st, t0, t1);
        do_look(3'd1, rdy, d);
        check("R5 pending entry not ready", rdy, 0);
        // broadcast and look up in the same cycle
        wb_valid = 1; wb_tag = 3'd1; wb_data = 32'hA5A5_0001; src_tag = 3'd1;
        #1;
        check("R4 bypass ready", src_ready, 1);
        check("R4 bypass data", src_data, 32'hA5A5_0001);
        @(posedge clk); #1;
        wb_valid = 0;
        do_look(3'd1, rdy, d);
        check("R4 ready after broadcast", rdy, 1);
        check("R4 data after broadcast", d, 32'hA5A5_0001);
        do_look(3'd0, rdy, d);
        check("R5 other entry still pending", rdy, 0);
        // broadcast to an unoccupied tag, observed in the same cycle and after
        wb_valid = 1; wb_tag = 3'd4; wb_data = 32'h77; src_tag = 3'd4;
        #1;
        check("R5 unoccupied bypass ignored", src_ready, 0);
        @(posedge clk); #1;
        wb_valid = 0;
        do_look(3'd4, rdy, d);
        check("R5 unoccupied stays not ready", rdy, 0);
    endtask

    task automatic t_retire_order();
        logic st; logic [TW-1:0] t0, t1; logic [1:0] dn; logic [DW-1:0] d;
        do_reset();
        do_retire(1, 1, dn);
        check("R6 empty pool retires nothing", dn, 2'b00);
        do_alloc(1, 1, 5'd7, 5'd9, st, t0, t1);
        do_wb(3'd1, 32'h11);
        do_retire(1, 1, dn);
        check("R6 oldest without data blocks both", dn, 2'b00);
        do_arch(5'd9, d);
        check("R6 younger not committed early", d, 0);
        do_wb(3'd0, 32'h22);
        do_retire(1, 1, dn);
        check("R6 both retire", dn, 2'b11);
        do_arch(5'd7, d);
        check("R6 arch r7", d, 32'h22);
        do_arch(5'd9, d);
        check("R6 arch r9", d, 32'h11);
    endtask

    task automatic t_same_dest();
        logic st; logic [TW-1:0] t0, t1; logic [1:0] dn; logic [DW-1:0] d;
        do_reset();
        do_alloc(1, 1, 5'd5, 5'd5, st, t0, t1);
        do_wb(3'd0, 32'hAA);
        do_wb(3'd1, 32'hBB);
        do_retire(1, 1, dn);
        check("R7 pair retired", dn, 2'b11);
        do_arch(5'd5, d);
        check("R7 younger value kept", d, 32'hBB);
    endtask

    task automatic t_reuse();
        logic st; logic [TW-1:0] t0, t1; logic [1:0] dn; logic rdy; logic [DW-1:0] d;
        do_reset();
        for (int k = 0; k < 3; k++) do_alloc(1, 1, AW'(2 * k + 1), AW'(2 * k + 2), st, t0, t1);
        do_wb(3'd0, 32'h1);
        do_wb(3'd1, 32'h2);
        do_retire(1, 1, dn);
        check("R6 retire before reuse", dn, 2'b11);
        do_alloc(1, 1, 5'd10, 5'd11, st, t0, t1);
        check("R9 wrapped grant no stall", st, 0);
        check("R9 wrapped tag0", t0, 0);
        check("R9 wrapped tag1", t1, 1);
        do_look(3'd0, rdy, d);
        check("R9 reused entry starts empty", rdy, 0);
    endtask

    task automatic t_squash();
        logic st; logic [TW-1:0] t0, t1; logic rdy; logic [DW-1:0] d;
        do_reset();
        do_alloc(1, 1, 5'd1, 5'd2, st, t0, t1);
        do_alloc(1, 1, 5'd3, 5'd4, st, t0, t1);
        do_wb(3'd0, 32'h10);
        do_wb(3'd2, 32'h30);
        // squash keeping one entry, retiring it and requesting an allocation
        sq_valid = 1; sq_keep = 3'd1; ret_en0 = 1; ret_en1 = 1; alloc_en0 = 1; alloc_dst0 = 5'd20;
        #1;
        check("R10 allocation stalled during squash", alloc_stall, 1);
        check("R8 kept entry retires", ret_done, 2'b01);
        @(posedge clk); #1;
        idle_inputs();
        do_arch(5'd1, d);
        check("R6 kept entry committed", d, 32'h10);
        do_arch(5'd20, d);
        check("R10 no entry granted in squash", d, 0);
        do_look(3'd2, rdy, d);
        check("R8 released entry not ready", rdy, 0);
        do_alloc(1, 0, 5'd6, 5'd0, st, t0, t1);
        check("R8 allocation resumes behind kept", t0, 1);
        do_wb(3'd1, 32'h66);
        // squash keeping nothing: ready oldest must not retire
        sq_valid = 1; sq_keep = 3'd0; ret_en0 = 1;
        #1;
        check("R8 released entry cannot retire", ret_done, 2'b00);
        @(posedge clk); #1;
        idle_inputs();
        do_arch(5'd6, d);
        check("R8 released value not committed", d, 0);
        do_alloc(1, 0, 5'd7, 5'd0, st, t0, t1);
        check("R8 keep zero restarts at head", t0, 1);
        do_look(3'd1, rdy, d);
        check("R9 regranted entry starts empty", rdy, 0);
        // keep larger than occupancy is limited to occupancy (one entry held)
        sq_valid = 1; sq_keep = 3'd5;
        @(posedge clk); #1;
        idle_inputs();
        do_alloc(1, 0, 5'd8, 5'd0, st, t0, t1);
        check("R8 keep clamped to occupancy", t0, 2);
    endtask

    initial begin
        t_reset_state();
        t_alloc_fill();
        t_forward();
        t_retire_order();
        t_same_dest();
        t_reuse();
        t_squash();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule